// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous SRAM

This block produces the word address for each beat of a four-beat burst into a synchronous SRAM. On every clock the advance/load control chooses one of two actions. In a load, the address on the external bus becomes the first address of a new burst. In an advance, an internal beat counter moves forward and the block generates the next address itself.

The two low address bits follow one of two orders, chosen when the burst is loaded. The linear order counts up modulo four from the start value. The interleaved order XORs the start value with the beat number. The upper address bits are carried through unchanged from the load. The address and the beat number are both registered, so each one appears on the clock edge after the one that captured its command. The burst length is a power-of-two parameter with a default of four, and the address width is also a parameter.

Top module: `burst_addr_gen`

## Requirements
- R1: When `adv_i` is 0 at a rising edge, after that edge `addr_o` equals the `addr_i` sampled at the edge and `beat_o` is 0.
- R2: When `adv_i` is 1 at a rising edge, after that edge `beat_o` equals its previous value plus one, modulo the burst length (4).
- R3: If `order_i` was 0 at the load, the low two bits of `addr_o` on beat b are (start + b) mod 4. For example, a start of 2 gives 2, 3, 0, 1.
- R4: If `order_i` was 1 at the load, the low two bits of `addr_o` on beat b are start XOR b. For example, a start of 1 gives 1, 0, 3, 2.
- R5: On the fourth advance after a load, `addr_o` returns to the loaded address and `beat_o` returns to 0.
- R6: During advances, bits above bit 1 of `addr_o` keep the values they had at the load.
- R7: `order_i` is sampled only in load cycles. A change of `order_i` while advancing has no effect on `addr_o` until the next load.
- R8: While `rst` is high, `addr_o` and `beat_o` are cleared to 0. Advancing after reset with no load gives the low bits 1, 2, 3, 0 with the upper bits at 0.
- R9: A load in the middle of a burst ends that burst at once. The next address is the new `addr_i`, with `beat_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | 1 = advance the burst, 0 = load a new start address |
| order_i | input | 1 | Burst order used at a load: 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | Start address on the external bus |
| addr_o | output | ADDR_W | Registered word address for the current beat |
| beat_o | output | BEAT_W | Registered beat index, 0 for the loaded address |

## Verification
The hardest case to reach from the ports is a change of `order_i` in the middle of a burst. This matters only for start values where the linear and interleaved orders differ, such as 1 and 3. The stimulus loads those starts and then toggles `order_i` on every advance. It also drives a long random run in which loads, advances and order changes are independent, so that loads land at every beat position and after full wraps. A behavioural model holding only a start value, a beat number and an order compares both outputs on every clock.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Burst order selected at load time.
  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_nxt_o,
  output logic [BEAT_W-1:0] beat_q_o
);

  // A load restarts at beat 0. An advance wraps naturally at 2**BEAT_W.
  always_comb begin
    if (adv_i) beat_nxt_o = beat_q_o + BEAT_W'(1);
    else       beat_nxt_o = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q_o <= '0;
    else     beat_q_o <= beat_nxt_o;
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> beat_q_o == $past(beat_q_o) + BEAT_W'(1)); // R2

  AST_BEAT_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> beat_q_o == '0); // R1

endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] start_q_o,
  output burst_order_e      order_q_o,
  output logic [ADDR_W-1:0] start_eff_o,
  output burst_order_e      order_eff_o
);

  // The effective start and order are the bus values in a load cycle and
  // the held values while advancing.
  always_comb begin
    if (adv_i) begin
      start_eff_o = start_q_o;
      order_eff_o = order_q_o;
    end else begin
      start_eff_o = addr_i;
      order_eff_o = burst_order_e'(order_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q_o <= '0;
      order_q_o <= ORD_INTERLEAVED;
    end else if (!adv_i) begin
      start_q_o <= addr_i;
      order_q_o <= burst_order_e'(order_i);
    end
  end

  AST_ORDER_HELD: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> $stable(order_q_o)); // R7

  AST_START_HELD: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> $stable(start_q_o)); // R6

endmodule

// File: rtl/burst_lowbit_map.sv
module burst_lowbit_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_low_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] low_o
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  // Linear order: modulo add over the low field.
  assign lin_low = start_low_i + beat_i;

  // Interleaved order: each bit flips independently, so it is built bit by bit.
  for (genvar gi = 0; gi < BEAT_W; gi++) begin : g_ilv
    assign ilv_low[gi] = start_low_i[gi] ^ beat_i[gi];
  end

  assign low_o = (order_i == ORD_LINEAR) ? lin_low : ilv_low;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BURST_LEN = 4,
  localparam int BEAT_W   = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);

  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] start_eff;
  burst_order_e      order_q;
  burst_order_e      order_eff;
  logic [BEAT_W-1:0] low_nxt;

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk        (clk),
    .rst        (rst),
    .adv_i      (adv_i),
    .beat_nxt_o (beat_nxt),
    .beat_q_o   (beat_q)
  );

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk         (clk),
    .rst         (rst),
    .adv_i       (adv_i),
    .order_i     (order_i),
    .addr_i      (addr_i),
    .start_q_o   (start_q),
    .order_q_o   (order_q),
    .start_eff_o (start_eff),
    .order_eff_o (order_eff)
  );

  burst_lowbit_map #(.BEAT_W(BEAT_W)) u_map (
    .start_low_i (start_eff[BEAT_W-1:0]),
    .beat_i      (beat_nxt),
    .order_i     (order_eff),
    .low_o       (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_o <= '0;
    else     addr_o <= {start_eff[ADDR_W-1:BEAT_W], low_nxt};
  end

  assign beat_o = beat_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> addr_o == $past(addr_i)); // R1

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])); // R6

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_i && order_q == ORD_LINEAR) |=>
      addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + BEAT_W'(1)); // R3

  AST_XOR_INVARIANT: assert property (@(posedge clk) disable iff (rst)
    (adv_i && order_q == ORD_INTERLEAVED) |=>
      (addr_o[BEAT_W-1:0] ^ beat_o) == $past(addr_o[BEAT_W-1:0] ^ beat_o)); // R4

  AST_WRAP_HOME: assert property (@(posedge clk) disable iff (rst)
    (adv_i && beat_o == BEAT_W'(BURST_LEN-1)) |=> addr_o == start_q); // R5

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int BEAT_W     = 2;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              adv_i = 1'b0;
  logic              order_i = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic [BEAT_W-1:0] beat_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model state.
  int m_start = 0;
  int m_beat  = 0;
  int m_order = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_LEN(4)) i_burst_addr_gen (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (adv_i),
    .order_i (order_i),
    .addr_i  (addr_i),
    .addr_o  (addr_o),
    .beat_o  (beat_o)
  );

  function automatic int model_addr();
    int low;
    if (m_order == 0) low = (m_start + m_beat) % 4;
    else              low = (m_start % 4) ^ m_beat;
    return (m_start / 4) * 4 + low;
  endfunction

  task automatic check_val(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, actual, expected, $time);
    end
  endtask

  // Drive at the falling edge, update the model at the rising edge and
  // compare at the next falling edge.
  task automatic cyc(input bit adv, input bit ord, input int addr, input string req);
    adv_i   = adv;
    order_i = ord;
    addr_i  = ADDR_W'(addr);
    @(posedge clk);
    if (rst) begin
      m_start = 0; m_beat = 0; m_order = 1;
    end else if (!adv) begin
      m_start = addr; m_beat = 0; m_order = ord;
    end else begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    check_val({req, " addr"}, int'(addr_o), model_addr());
    check_val({req, " beat"}, int'(beat_o), m_beat);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    cyc(1'b0, 1'b0, 'h12345, "R8 reset");
    check_val("R8 reset addr zero", int'(addr_o), 0);
    check_val("R8 reset beat zero", int'(beat_o), 0);
    rst = 1'b0;

    // R8: advance with no load after reset.
    for (int i = 1; i <= 4; i++) begin
      cyc(1'b1, 1'b0, 'hFFFFF, "R8 adv-from-zero");
      check_val("R8 literal", int'(addr_o), i % 4);
    end

    // R3: linear, start 2 -> 2,3,0,1, then R5 wrap.
    cyc(1'b0, 1'b0, 'hABCD2, "R1 load");
    check_val("R3 beat0", int'(addr_o[1:0]), 2);
    cyc(1'b1, 1'b0, 0, "R3"); check_val("R3 beat1", int'(addr_o[1:0]), 3);
    cyc(1'b1, 1'b0, 0, "R3"); check_val("R3 beat2", int'(addr_o[1:0]), 0);
    cyc(1'b1, 1'b0, 0, "R3"); check_val("R3 beat3", int'(addr_o[1:0]), 1);
    check_val("R6 upper", int'(addr_o[ADDR_W-1:2]), 'hABCD2 >> 2);
    cyc(1'b1, 1'b0, 0, "R5");
    check_val("R5 wrap addr", int'(addr_o), 'hABCD2);
    check_val("R5 wrap beat", int'(beat_o), 0);

    // R4: interleaved, start 1 -> 1,0,3,2.
    cyc(1'b0, 1'b1, 'h00F01, "R1 load");
    check_val("R4 beat0", int'(addr_o[1:0]), 1);
    cyc(1'b1, 1'b1, 0, "R4"); check_val("R4 beat1", int'(addr_o[1:0]), 0);
    cyc(1'b1, 1'b1, 0, "R4"); check_val("R4 beat2", int'(addr_o[1:0]), 3);
    cyc(1'b1, 1'b1, 0, "R4"); check_val("R4 beat3", int'(addr_o[1:0]), 2);
    cyc(1'b1, 1'b1, 0, "R5"); check_val("R5 wrap ilv", int'(addr_o), 'h00F01);

    // R7: order toggled while advancing, linear start 3 -> 3,0,1,2.
    cyc(1'b0, 1'b0, 'h55553, "R1 load");
    cyc(1'b1, 1'b1, 0, "R7"); check_val("R7 beat1 held", int'(addr_o[1:0]), 0);
    cyc(1'b1, 1'b0, 0, "R7"); check_val("R7 beat2 held", int'(addr_o[1:0]), 1);
    cyc(1'b1, 1'b1, 0, "R7"); check_val("R7 beat3 held", int'(addr_o[1:0]), 2);

    // R7: interleaved start 3 with order dropped -> 3,2,1,0.
    cyc(1'b0, 1'b1, 'h00003, "R1 load");
    cyc(1'b1, 1'b0, 0, "R7"); check_val("R7 ilv beat1", int'(addr_o[1:0]), 2);
    cyc(1'b1, 1'b0, 0, "R7"); check_val("R7 ilv beat2", int'(addr_o[1:0]), 1);

    // R9: load in mid-burst.
    cyc(1'b0, 1'b0, 'h7777E, "R9 reload");
    check_val("R9 new addr", int'(addr_o), 'h7777E);
    check_val("R9 beat restart", int'(beat_o), 0);
    cyc(1'b1, 1'b0, 0, "R9"); check_val("R9 next", int'(addr_o), 'h7777F);

    // Random mix for R1..R7, R9.
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 4) != 0, 1'($urandom), int'($urandom % (1 << ADDR_W)), "R2 random");
    end

    // R8: reset in the middle of a burst.
    cyc(1'b0, 1'b0, 'h12346, "R1 load");
    rst = 1'b1;
    cyc(1'b1, 1'b0, 0, "R8 midreset");
    rst = 1'b0;
    cyc(1'b1, 1'b0, 0, "R8 post");
    check_val("R8 post literal", int'(addr_o), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule